// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Formatter

This block produces the byte a four-channel serial controller places on its data bus when the host runs an interrupt acknowledge cycle. A fixed-priority arbiter looks at the pending interrupt sources of every channel. Each channel can have four sources: receiver with error, receiver, transmitter, and any other source. The arbiter picks one winning channel and one source class. That choice is frozen when the acknowledge strobe begins.

A 2-bit mode field sets how the vector byte is built. In the first mode no vector is supplied and the bus reads all ones. In the second the programmed vector register is passed through unchanged. In the third the channel code is spliced into the vector register. In the fourth both a source-type code and the channel code are spliced in. A bus-drive enable tells the surrounding bus logic when to put the byte on the pins. While power-down is set, arbitration stops and no new winner is taken.

Top module: `ivec_formatter_top`

## Requirements
- R1: After reset, `bus_drive` is 0.
- R2: In mode 2'b00, `vec_out` is 8'hFF and `bus_drive` is asserted during the acknowledge strobe, even if no interrupt is pending.
- R3: In mode 2'b01, `vec_out` equals `vec_reg` unchanged.
- R4: In mode 2'b10, `vec_out[2:0]` is the 3-bit channel code and `vec_out[7:3]` comes from `vec_reg[7:3]`. The channel code is the channel index with a 0 in the upper bit.
- R5: In mode 2'b11, `vec_out[7:5]` comes from `vec_reg[7:5]`, `vec_out[4:3]` is the type code and `vec_out[2:0]` is the channel code.
- R6: The type code is 2'b11 for receiver with error, 2'b10 for receiver, 2'b01 for transmitter and 2'b00 for any other source.
- R7: Among channels, the lowest-numbered channel with any pending source wins.
- R8: Within the winning channel, sources rank as receiver with error, then receiver, then transmitter, then other.
- R9: The winner is captured on the first rising clock edge that sees `ack_n` low. It stays unchanged until `ack_n` returns high, even if the requests change in the meantime.
- R10: If `pwr_down` is 1 at the capture edge, no winner is taken. In modes 2'b01 to 2'b11 the bus is then not driven.
- R11: `bus_drive` is 1 only after the capture edge while `ack_n` stays low, and only if a winner was taken or the mode is 2'b00. It drops as soon as `ack_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Power-down; stops arbitration |
| vec_reg | input | 8 | Programmed interrupt vector |
| vec_mode | input | 2 | Vector build mode |
| ack_n | input | 1 | Active-low interrupt acknowledge strobe |
| req_rxerr | input | 4 | Receiver-with-error request, one bit per channel |
| req_rx | input | 4 | Receiver request, one bit per channel |
| req_tx | input | 4 | Transmitter request, one bit per channel |
| req_oth | input | 4 | Other-source request, one bit per channel |
| vec_out | output | 8 | Vector byte for the data bus |
| bus_drive | output | 1 | Drive enable for the vector byte |

## Verification
Each of the four modes is run with a single pending source. This separates pass-through from the two splice layouts and from the all-ones answer. The fourth mode is run once with each source class, which exposes any swap in the type code. Conflicting requests show channel priority when they sit on different channels, and class priority when they share one channel. Requests that change in the middle of a strobe test the capture point. Power-down strobes and strobes with nothing pending separate the drive condition of mode 00 from that of the other modes.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
   typedef enum logic [1:0] {
      SRC_OTHER = 2'b00,
      SRC_TX    = 2'b01,
      SRC_RX    = 2'b10,
      SRC_RXERR = 2'b11
   } src_cls_e;

   typedef enum logic [1:0] {
      VM_NONE   = 2'b00,
      VM_PLAIN  = 2'b01,
      VM_CHAN   = 2'b10,
      VM_TYPED  = 2'b11
   } vmode_e;
endpackage

// File: rtl/ivec_arbiter.sv
module ivec_arbiter
   import ivec_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_down,
   input  logic [NUM_CH-1:0] req_rxerr,
   input  logic [NUM_CH-1:0] req_rx,
   input  logic [NUM_CH-1:0] req_tx,
   input  logic [NUM_CH-1:0] req_oth,
   output logic              win_valid,
   output logic [CH_W-1:0]   win_ch,
   output src_cls_e          win_cls
);
   logic [NUM_CH-1:0] pend;
   src_cls_e          ch_cls [NUM_CH];

   // per-channel source ranking
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign pend[c] = req_rxerr[c] | req_rx[c] | req_tx[c] | req_oth[c];
      always_comb begin
         if (req_rxerr[c])   ch_cls[c] = SRC_RXERR;
         else if (req_rx[c]) ch_cls[c] = SRC_RX;
         else if (req_tx[c]) ch_cls[c] = SRC_TX;
         else                ch_cls[c] = SRC_OTHER;
      end
   end

   // lowest index wins; scanning downward lets it overwrite the rest
   always_comb begin
      win_ch  = '0;
      win_cls = SRC_OTHER;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
         if (pend[c]) begin
            win_ch  = c[CH_W-1:0];
            win_cls = ch_cls[c];
         end
      end
      win_valid = (|pend) & ~pwr_down;
   end

   p_pd_no_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> !win_valid);
   p_winner_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> pend[win_ch]);
   p_no_lower_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> ((pend & ~({NUM_CH{1'b1}} << win_ch)) == '0));
endmodule

// File: rtl/ivec_hold.sv
module ivec_hold
   import ivec_pkg::*;
#(
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ack_n,
   input  logic            win_valid,
   input  logic [CH_W-1:0] win_ch,
   input  src_cls_e        win_cls,
   output logic            strobe_q,
   output logic            held_valid,
   output logic [CH_W-1:0] held_ch,
   output src_cls_e        held_cls
);
   logic capture;
   assign capture = ~ack_n & ~strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q   <= 1'b0;
         held_valid <= 1'b0;
         held_ch    <= '0;
         held_cls   <= SRC_OTHER;
      end else begin
         strobe_q <= ~ack_n;
         if (capture) begin
            held_valid <= win_valid;
            held_ch    <= win_ch;
            held_cls   <= win_cls;
         end
      end
   end

   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_q && !ack_n) |=> ($stable(held_valid) && $stable(held_ch) && $stable(held_cls)));
endmodule

// File: rtl/ivec_format.sv
module ivec_format
   import ivec_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int CODE_W = 3,
   parameter int CH_W   = 2,
   localparam int TYPE_LO = CODE_W,
   localparam int KEEP_LO = CODE_W + 2
) (
   input  vmode_e          mode,
   input  logic [VEC_W-1:0] vec_reg,
   input  logic [CH_W-1:0]  held_ch,
   input  src_cls_e         held_cls,
   output logic [VEC_W-1:0] vec_out
);
   if (VEC_W < KEEP_LO + 1) begin : g_bad_width
      $error("ivec_format: VEC_W too small for the typed layout");
   end
   if (CH_W > CODE_W) begin : g_bad_code
      $error("ivec_format: channel index wider than channel code");
   end

   logic [CODE_W-1:0] code;
   assign code = CODE_W'(held_ch);

   always_comb begin
      unique case (mode)
         VM_NONE:  vec_out = '1;
         VM_PLAIN: vec_out = vec_reg;
         VM_CHAN:  vec_out = {vec_reg[VEC_W-1:TYPE_LO], code};
         VM_TYPED: vec_out = {vec_reg[VEC_W-1:KEEP_LO], held_cls, code};
         default:  vec_out = '1;
      endcase
   end
endmodule

// File: rtl/ivec_formatter_top.sv
module ivec_formatter_top
   import ivec_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int VEC_W  = 8,
   parameter int CODE_W = 3,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_down,
   input  logic [VEC_W-1:0]  vec_reg,
   input  logic [1:0]        vec_mode,
   input  logic              ack_n,
   input  logic [NUM_CH-1:0] req_rxerr,
   input  logic [NUM_CH-1:0] req_rx,
   input  logic [NUM_CH-1:0] req_tx,
   input  logic [NUM_CH-1:0] req_oth,
   output logic [VEC_W-1:0]  vec_out,
   output logic              bus_drive
);
   logic            win_valid, strobe_q, held_valid;
   logic [CH_W-1:0] win_ch, held_ch;
   src_cls_e        win_cls, held_cls;
   vmode_e          mode;

   assign mode = vmode_e'(vec_mode);

   ivec_arbiter #(.NUM_CH(NUM_CH)) u_arb (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
      .req_rxerr(req_rxerr), .req_rx(req_rx), .req_tx(req_tx), .req_oth(req_oth),
      .win_valid(win_valid), .win_ch(win_ch), .win_cls(win_cls)
   );

   ivec_hold #(.CH_W(CH_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .ack_n(ack_n),
      .win_valid(win_valid), .win_ch(win_ch), .win_cls(win_cls),
      .strobe_q(strobe_q), .held_valid(held_valid),
      .held_ch(held_ch), .held_cls(held_cls)
   );

   ivec_format #(.VEC_W(VEC_W), .CODE_W(CODE_W), .CH_W(CH_W)) u_fmt (
      .mode(mode), .vec_reg(vec_reg), .held_ch(held_ch),
      .held_cls(held_cls), .vec_out(vec_out)
   );

   assign bus_drive = strobe_q & ~ack_n & (held_valid | (mode == VM_NONE));

   p_drive_in_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> !ack_n);
   p_none_all_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drive && vec_mode == 2'b00) |-> (vec_out == '1));
   p_plain_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drive && vec_mode == 2'b01) |-> (vec_out == vec_reg));
   p_chan_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_mode == 2'b10) |-> (vec_out[VEC_W-1:CODE_W] == vec_reg[VEC_W-1:CODE_W]));
endmodule

// File: tb/tb_ivec_formatter_top.sv
module tb_ivec_formatter_top;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       pwr_down = 0;
   logic [7:0] vec_reg = 8'hA5;
   logic [1:0] vec_mode = 2'b00;
   logic       ack_n = 1;
   logic [3:0] req_rxerr = 0, req_rx = 0, req_tx = 0, req_oth = 0;
   logic [7:0] vec_out;
   logic       bus_drive;

   int n_chk = 0, n_fail = 0;

   ivec_formatter_top dut (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .vec_reg(vec_reg),
      .vec_mode(vec_mode), .ack_n(ack_n), .req_rxerr(req_rxerr), .req_rx(req_rx),
      .req_tx(req_tx), .req_oth(req_oth), .vec_out(vec_out), .bus_drive(bus_drive)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model: strobe tracking and a captured winner
   bit m_strobe = 0, m_valid = 0;
   int m_ch = 0, m_type = 0;

   function automatic void pick(output bit v, output int ch, output int ty);
      v = 0; ch = 0; ty = 0;
      for (int c = 0; c < 4; c++) begin
         if (!v && (req_rxerr[c] | req_rx[c] | req_tx[c] | req_oth[c])) begin
            v = 1; ch = c;
            if (req_rxerr[c]) ty = 3;
            else if (req_rx[c]) ty = 2;
            else if (req_tx[c]) ty = 1;
            else ty = 0;
         end
      end
   endfunction

   function automatic int model_byte();
      case (vec_mode)
         2'b00: return 8'hFF;
         2'b01: return vec_reg;
         2'b10: return (vec_reg & 8'hF8) | m_ch;
         default: return (vec_reg & 8'hE0) | (m_type << 3) | m_ch;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_strobe = 0; m_valid = 0; m_ch = 0; m_type = 0;
      end else begin
         if (!ack_n && !m_strobe) begin
            bit v; int ch, ty;
            pick(v, ch, ty);
            m_valid = v && !pwr_down;
            m_ch = ch; m_type = ty;
         end
         m_strobe = !ack_n;
      end
      #3;
      if (rst_n) begin
         bit exp_drv;
         exp_drv = m_strobe && !ack_n && (m_valid || vec_mode == 2'b00);
         check(bus_drive == exp_drv, "R11 model drive", bus_drive, exp_drv);
         if (exp_drv)
            check(vec_out == model_byte(), "R2/R3/R4/R5 model byte", vec_out, model_byte());
      end
   end

   task automatic clear_req();
      req_rxerr = 0; req_rx = 0; req_tx = 0; req_oth = 0;
   endtask

   // run one acknowledge strobe and check the byte in the held phase
   task automatic strobe(input bit exp_drv, input logic [7:0] exp_byte, input string req);
      @(negedge clk); ack_n = 0;
      @(posedge clk); @(posedge clk); #3;
      check(bus_drive == exp_drv, req, bus_drive, exp_drv);
      if (exp_drv) check(vec_out == exp_byte, req, vec_out, exp_byte);
      @(negedge clk); ack_n = 1; #1;
      check(bus_drive == 0, "R11 release", bus_drive, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(bus_drive == 0, "R1 reset", bus_drive, 0);
      rst_n = 1;
      @(negedge clk);

      vec_mode = 2'b00; strobe(1, 8'hFF, "R2 none mode");
      req_tx[2] = 1;
      vec_mode = 2'b01; strobe(1, 8'hA5, "R3 plain");
      vec_mode = 2'b10; strobe(1, 8'hA2, "R4 channel splice");
      vec_mode = 2'b11; strobe(1, 8'hAA, "R5 typed tx");
      clear_req(); req_rxerr[1] = 1; strobe(1, 8'hB9, "R6 rx error type");
      clear_req(); req_rx[3] = 1;    strobe(1, 8'hB3, "R6 rx type");
      clear_req(); req_oth[0] = 1;   strobe(1, 8'hA0, "R6 other type");
      clear_req(); req_tx[1] = 1; req_rxerr[3] = 1; strobe(1, 8'hA9, "R7 channel priority");
      clear_req(); req_tx[2] = 1; req_rx[2] = 1; req_oth[2] = 1; strobe(1, 8'hB2, "R8 class priority");

      // R9: requests change after capture
      clear_req(); req_rx[3] = 1;
      @(negedge clk); ack_n = 0;
      @(posedge clk); @(negedge clk); req_rxerr[0] = 1; req_rx[3] = 0;
      @(posedge clk); #3;
      check(vec_out == 8'hB3, "R9 held winner", vec_out, 8'hB3);
      check(bus_drive == 1, "R9 held drive", bus_drive, 1);
      @(negedge clk); ack_n = 1;
      @(negedge clk);
      strobe(1, 8'hB8, "R9 next strobe recaptures");

      // R10: power-down blocks arbitration
      clear_req(); req_tx[2] = 1; pwr_down = 1;
      strobe(0, 8'h00, "R10 powered down typed");
      vec_mode = 2'b00; strobe(1, 8'hFF, "R10 powered down none mode");
      pwr_down = 0;

      // R11: nothing pending, vector modes do not drive
      clear_req(); vec_mode = 2'b01; strobe(0, 8'h00, "R11 idle plain");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule